// File: doc/BRIEF.md
# Dual Round-Robin Crossbar Matcher

This block schedules an N-port crossbar whose inputs keep one queue per output. For each time slot it is handed a square occupancy bitmap that says which input holds cells for which output. It then works out a conflict-free pairing of inputs to outputs, and the crossbar uses that pairing in the following slot. Each iteration has three phases. First, every unmatched input sends one request, picking round-robin from the unmatched outputs it holds cells for. Next, every unmatched output grants one of its requesters, again round-robin. Finally, every input accepts the grant addressed to it.

The block runs one iteration per clock cycle and a parameter sets how many iterations a slot gets. An input or output matched in an earlier iteration is left out of the later ones in the same slot. Each input and output keeps its own pointer. These pointers move only on the first iteration of a slot, so arbitration stays fair from slot to slot. The result comes out as a per-input output index with a valid bit and as a per-output one-hot grant vector. A single-cycle done pulse marks the point where the result is final.

Top module: `drr_matcher`

## Requirements
- R1: After reset, `match_valid`, `out_grant` and `done` are all zero and every round-robin pointer is 0.
- R2: `start` is taken when the block is idle. `done` is then high for exactly one cycle, the cycle after the ITERS-th rising edge that follows the edge that took `start`.
- R3: Occupancy bit `occ[i*NPORT+j]` means input i holds cells for output j. In each iteration an unmatched input requests exactly one output. It searches cyclically starting at its own pointer and takes the first output that is occupied and still unmatched.
- R4: Each output grants the first requesting input found by a cyclic search that starts at the output's pointer.
- R5: No output is paired with more than one input. Bit `out_grant[j*NPORT+i]` is set exactly when `match_valid[i]` is set and `match_idx[i*IDXW +: IDXW]` equals j. Pairs are formed only where the occupancy bit was set.
- R6: Once an input or output is matched, it stays matched and takes no further part in that slot. With ITERS equal to NPORT, the final result leaves no occupied pair in which both the input and the output are unmatched.
- R7: When input i and output j are matched in the first iteration, the input pointer becomes (j+1) mod NPORT and the output pointer becomes (i+1) mod NPORT. Matches made in later iterations leave both pointers where they are.
- R8: A `start` that arrives while iterations are running is ignored, and so is the occupancy presented with it.
- R9: Between `done` and the next accepted `start`, the match outputs hold their values.
- R10: An all-zero occupancy still produces the `done` pulse, with no valid match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a slot; occupancy sampled on the same edge |
| occ | input | NPORT*NPORT | Occupancy bitmap, bit i*NPORT+j = input i has cells for output j |
| done | output | 1 | One-cycle pulse: match is final |
| match_valid | output | NPORT | Input i is matched |
| match_idx | output | NPORT*IDXW | Output index for input i in bits i*IDXW +: IDXW |
| out_grant | output | NPORT*NPORT | Bit j*NPORT+i: output j is paired with input i |

## Verification
The tests use several occupancy patterns. A full bitmap from reset pointers shows that the block matches greedily across iterations. A second full bitmap then shows that the pointers moved and changed the outcome. A single input with several queues makes the input pointer step through the queues and wrap around. Three inputs that compete for one output show the output pointer rotating. A two-input pattern whose second pair is matched in iteration two separates first-iteration pointer updates from later ones. An idle start, a start issued mid-slot, and a stream of pseudo-random bitmaps complete the tests. The random bitmaps are checked for uniqueness, for agreement between the two output forms, and for maximality.

// File: rtl/drr_pkg.sv
package drr_pkg;

   // Cyclic successor of a port number.
   function automatic int wrap_inc(input int v, input int n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction

   // Arbiter implementation selectors.
   localparam int ARB_SCAN = 0;
   localparam int ARB_MASK = 1;

endpackage

// File: rtl/drr_rr_pick.sv
module drr_rr_pick #(
   parameter int N    = 4,
   parameter int W    = 2,
   parameter int IMPL = drr_pkg::ARB_SCAN
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] ptr,
   output logic [N-1:0] gnt,
   output logic [W-1:0] idx,
   output logic         any
);

   assign any = |req;

   generate
      if (IMPL == drr_pkg::ARB_SCAN) begin : g_scan
         // Walk from the pointer around the ring, first hit wins.
         always_comb begin
            logic found;
            int   pos;
            gnt   = '0;
            idx   = '0;
            found = 1'b0;
            for (int k = 0; k < N; k++) begin
               pos = int'(ptr) + k;
               if (pos >= N) pos = pos - N;
               if (!found && req[pos]) begin
                  found    = 1'b1;
                  gnt[pos] = 1'b1;
                  idx      = W'(pos);
               end
            end
         end
      end else begin : g_mask
         // Thermometer mask: lowest request at or above pointer, else lowest overall.
         logic [N-1:0] upper;
         logic [N-1:0] sel;
         always_comb begin
            for (int b = 0; b < N; b++) begin
               upper[b] = req[b] && (W'(b) >= ptr);
            end
            sel = (|upper) ? upper : req;
            gnt = sel & (~sel + N'(1));
            idx = '0;
            for (int b = 0; b < N; b++) begin
               if (gnt[b]) idx = W'(b);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/drr_request_stage.sv
module drr_request_stage #(
   parameter int N    = 4,
   parameter int W    = 2,
   parameter int IMPL = drr_pkg::ARB_SCAN
) (
   input  logic [N*N-1:0] occ,
   input  logic [N-1:0]   in_busy,
   input  logic [N-1:0]   out_busy,
   input  logic [N*W-1:0] in_ptr,
   output logic [N*N-1:0] req
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_in
         logic [N-1:0] cand;
         logic [W-1:0] pick_idx;
         logic         pick_any;

         assign cand = occ[i*N +: N] & ~out_busy & {N{~in_busy[i]}};

         drr_rr_pick #(.N(N), .W(W), .IMPL(IMPL)) u_pick (
            .req (cand),
            .ptr (in_ptr[i*W +: W]),
            .gnt (req[i*N +: N]),
            .idx (pick_idx),
            .any (pick_any)
         );
      end
   endgenerate

endmodule

// File: rtl/drr_grant_stage.sv
module drr_grant_stage #(
   parameter int N    = 4,
   parameter int W    = 2,
   parameter int IMPL = drr_pkg::ARB_SCAN
) (
   input  logic [N*N-1:0] req,
   input  logic [N-1:0]   out_busy,
   input  logic [N*W-1:0] out_ptr,
   output logic [N*N-1:0] gnt
);

   generate
      for (genvar j = 0; j < N; j++) begin : g_out
         logic [N-1:0] col;
         logic [W-1:0] pick_idx;
         logic         pick_any;

         for (genvar i = 0; i < N; i++) begin : g_col
            assign col[i] = req[i*N + j] & ~out_busy[j];
         end

         drr_rr_pick #(.N(N), .W(W), .IMPL(IMPL)) u_pick (
            .req (col),
            .ptr (out_ptr[j*W +: W]),
            .gnt (gnt[j*N +: N]),
            .idx (pick_idx),
            .any (pick_any)
         );
      end
   endgenerate

endmodule

// File: rtl/drr_accept_stage.sv
module drr_accept_stage #(
   parameter int N    = 4,
   parameter int W    = 2,
   parameter int IMPL = drr_pkg::ARB_SCAN
) (
   input  logic [N*N-1:0] req,
   input  logic [N*N-1:0] gnt,
   input  logic [N*W-1:0] in_ptr,
   output logic [N*N-1:0] acc
);

   generate
      for (genvar i = 0; i < N; i++) begin : g_in
         logic [N-1:0] offer;
         logic [W-1:0] pick_idx;
         logic         pick_any;

         for (genvar j = 0; j < N; j++) begin : g_off
            assign offer[j] = gnt[j*N + i] & req[i*N + j];
         end

         drr_rr_pick #(.N(N), .W(W), .IMPL(IMPL)) u_pick (
            .req (offer),
            .ptr (in_ptr[i*W +: W]),
            .gnt (acc[i*N +: N]),
            .idx (pick_idx),
            .any (pick_any)
         );
      end
   endgenerate

endmodule

// File: rtl/drr_matcher.sv
module drr_matcher #(
   parameter int NPORT    = 4,
   parameter int ITERS    = 2,
   parameter int ARB_IMPL = drr_pkg::ARB_SCAN,
   parameter int IDXW     = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [NPORT*NPORT-1:0] occ,
   output logic                   done,
   output logic [NPORT-1:0]       match_valid,
   output logic [NPORT*IDXW-1:0]  match_idx,
   output logic [NPORT*NPORT-1:0] out_grant
);

   localparam int NN = NPORT * NPORT;
   localparam int CW = (ITERS > 1) ? $clog2(ITERS) : 1;
   localparam logic [CW-1:0] LAST_IT = CW'(ITERS - 1);

   // Elaboration-time parameter checks.
   generate
      if (NPORT < 2) begin : g_bad_nport
         $error("drr_matcher: NPORT must be at least 2");
      end
      if (ITERS < 1 || ITERS > NPORT) begin : g_bad_iters
         $error("drr_matcher: ITERS must lie in 1..NPORT");
      end
      if (ARB_IMPL != drr_pkg::ARB_SCAN && ARB_IMPL != drr_pkg::ARB_MASK) begin : g_bad_impl
         $error("drr_matcher: unknown ARB_IMPL");
      end
      if (IDXW < $clog2(NPORT)) begin : g_bad_idxw
         $error("drr_matcher: IDXW too narrow for NPORT");
      end
   endgenerate

   logic [NN-1:0]         occ_q;
   logic [NPORT-1:0]      in_m_q;
   logic [NN-1:0]         gnt_q;
   logic [NPORT*IDXW-1:0] idx_q;
   logic [NPORT*IDXW-1:0] in_ptr_q;
   logic [NPORT*IDXW-1:0] out_ptr_q;
   logic                  busy_q;
   logic [CW-1:0]         it_q;
   logic                  done_q;

   logic [NPORT-1:0]      out_m;
   logic [NN-1:0]         req_v;
   logic [NN-1:0]         gnt_v;
   logic [NN-1:0]         acc_v;

   always_comb begin
      for (int j = 0; j < NPORT; j++) begin
         out_m[j] = |gnt_q[j*NPORT +: NPORT];
      end
   end

   drr_request_stage #(.N(NPORT), .W(IDXW), .IMPL(ARB_IMPL)) u_req (
      .occ      (occ_q),
      .in_busy  (in_m_q),
      .out_busy (out_m),
      .in_ptr   (in_ptr_q),
      .req      (req_v)
   );

   drr_grant_stage #(.N(NPORT), .W(IDXW), .IMPL(ARB_IMPL)) u_gnt (
      .req      (req_v),
      .out_busy (out_m),
      .out_ptr  (out_ptr_q),
      .gnt      (gnt_v)
   );

   drr_accept_stage #(.N(NPORT), .W(IDXW), .IMPL(ARB_IMPL)) u_acc (
      .req      (req_v),
      .gnt      (gnt_v),
      .in_ptr   (in_ptr_q),
      .acc      (acc_v)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q     <= '0;
         in_m_q    <= '0;
         gnt_q     <= '0;
         idx_q     <= '0;
         in_ptr_q  <= '0;
         out_ptr_q <= '0;
         busy_q    <= 1'b0;
         it_q      <= '0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && start) begin
            occ_q  <= occ;
            in_m_q <= '0;
            gnt_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b1;
            it_q   <= '0;
         end else if (busy_q) begin
            for (int i = 0; i < NPORT; i++) begin
               for (int j = 0; j < NPORT; j++) begin
                  if (acc_v[i*NPORT + j]) begin
                     in_m_q[i]                 <= 1'b1;
                     idx_q[i*IDXW +: IDXW]     <= IDXW'(j);
                     gnt_q[j*NPORT + i]        <= 1'b1;
                     if (it_q == '0) begin
                        in_ptr_q[i*IDXW +: IDXW]  <= IDXW'(drr_pkg::wrap_inc(j, NPORT));
                        out_ptr_q[j*IDXW +: IDXW] <= IDXW'(drr_pkg::wrap_inc(i, NPORT));
                     end
                  end
               end
            end
            if (it_q == LAST_IT) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end else begin
               it_q <= it_q + CW'(1);
            end
         end
      end
   end

   assign done        = done_q;
   assign match_valid = in_m_q;
   assign match_idx   = idx_q;
   assign out_grant   = gnt_q;

endmodule

// File: rtl/drr_matcher_chk.sv
module drr_matcher_chk #(
   parameter int N = 4,
   parameter int W = 2
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy_q,
   input logic           done,
   input logic [N*N-1:0] occ_q,
   input logic [N-1:0]   match_valid,
   input logic [N*W-1:0] match_idx,
   input logic [N*N-1:0] out_grant
);

   // R2: done lasts a single cycle and follows the busy phase.
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy_q && $past(busy_q)));

   // R8: occupancy captured for a slot does not change mid-slot.
   p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start) |=> $stable(occ_q));

   // R9: results hold while idle with no start.
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && !start) |=> ($stable(match_valid) && $stable(out_grant) && $stable(match_idx)));

   generate
      for (genvar j = 0; j < N; j++) begin : g_out
         // R5: an output is paired with at most one input.
         p_out_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(out_grant[j*N +: N]));
      end
      for (genvar i = 0; i < N; i++) begin : g_in
         logic [N-1:0] col;
         for (genvar j = 0; j < N; j++) begin : g_col
            assign col[j] = out_grant[j*N + i];
         end
         // R5: an input appears in at most one output's grant vector.
         p_in_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(col) == int'(match_valid[i]));
         // R5: the index and grant forms agree, and pairs sit on occupied queues.
         p_idx_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
            match_valid[i] |-> out_grant[int'(match_idx[i*W +: W])*N + i]);
         p_on_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
            match_valid[i] |-> occ_q[i*N + int'(match_idx[i*W +: W])]);
         // R6: a matched input stays matched for the rest of the slot.
         p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && match_valid[i]) |=> (match_valid[i] && $stable(match_idx[i*W +: W])));
      end
   endgenerate

endmodule

bind drr_matcher drr_matcher_chk #(.N(NPORT), .W(IDXW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy_q      (busy_q),
   .done        (done),
   .occ_q       (occ_q),
   .match_valid (match_valid),
   .match_idx   (match_idx),
   .out_grant   (out_grant)
);

// File: tb/drr_matcher_tb.sv
module drr_matcher_tb;

   localparam int N  = 4;
   localparam int IT = 4;
   localparam int W  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [N*N-1:0] occ = '0;
   logic           done;
   logic [N-1:0]   match_valid;
   logic [N*W-1:0] match_idx;
   logic [N*N-1:0] out_grant;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   drr_matcher #(.NPORT(N), .ITERS(IT), .ARB_IMPL(drr_pkg::ARB_SCAN), .IDXW(W)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .occ         (occ),
      .done        (done),
      .match_valid (match_valid),
      .match_idx   (match_idx),
      .out_grant   (out_grant)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [N*N-1:0] grant_of(input logic [N-1:0] v, input logic [N*W-1:0] ix);
      logic [N*N-1:0] g = '0;
      for (int i = 0; i < N; i++) begin
         if (v[i]) g[int'(ix[i*W +: W])*N + i] = 1'b1;
      end
      return g;
   endfunction

   // One slot; checks done timing (R2).
   task automatic run_slot(input logic [N*N-1:0] pattern);
      int first_done = -1;
      int count_done = 0;
      @(negedge clk);
      occ   = pattern;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      occ   = '0;
      for (int k = 1; k <= IT + 1; k++) begin
         if (k > 1 || 1) @(negedge clk);
         if (done) begin
            count_done++;
            if (first_done < 0) first_done = k;
         end
      end
      check(first_done == IT && count_done == 1, "R2", "done position/count",
            32'(first_done * 16 + count_done), 32'(IT * 16 + 1));
   endtask

   task automatic expect_match(input string req, input logic [N-1:0] ev, input logic [N*W-1:0] ei);
      logic [N*W-1:0] mask = '0;
      for (int i = 0; i < N; i++) if (ev[i]) mask[i*W +: W] = '1;
      check(match_valid == ev, req, "match_valid", 32'(match_valid), 32'(ev));
      check((match_idx & mask) == ei, req, "match_idx", 32'(match_idx & mask), 32'(ei));
      check(out_grant == grant_of(ev, ei), req, "out_grant", 32'(out_grant), 32'(grant_of(ev, ei)));
   endtask

   task automatic t_reset();
      check(match_valid == '0 && out_grant == '0 && done == 1'b0, "R1", "reset outputs",
            32'({done, match_valid, out_grant}), 32'h0);
   endtask

   task automatic t_full_twice();
      // Reset pointers: greedy diagonal (R1 pointers at 0, R3/R4/R6).
      run_slot('1);
      expect_match("R6", 4'b1111, 8'hE4);
      // Pointers moved by first iteration change the outcome (R7).
      run_slot('1);
      expect_match("R7", 4'b1111, 8'hE1);
   endtask

   task automatic t_input_rotation();
      // Input 2 holds cells for outputs 0,1,3 (R3 cyclic request, wrap).
      run_slot(16'h0B00);
      expect_match("R3", 4'b0100, 8'h00);
      run_slot(16'h0B00);
      expect_match("R3", 4'b0100, 8'h10);
      run_slot(16'h0B00);
      expect_match("R3", 4'b0100, 8'h30);
   endtask

   task automatic t_output_rotation();
      // Inputs 0,1,3 compete for output 2 (R4).
      run_slot(16'h4044);
      expect_match("R4", 4'b0001, 8'h02);
      run_slot(16'h4044);
      expect_match("R4", 4'b0010, 8'h08);
      run_slot(16'h4044);
      expect_match("R4", 4'b1000, 8'h80);
   endtask

   task automatic t_late_iteration();
      // Pair (1,1) formed in iteration two (R6).
      run_slot(16'h0031);
      expect_match("R6", 4'b0011, 8'h04);
      // Input 1 pointer must still be 3, so it picks output 3 not 2 (R7).
      run_slot(16'h00C0);
      expect_match("R7", 4'b0010, 8'h0C);
   endtask

   task automatic t_busy_start();
      logic [N*N-1:0] g_hold;
      int dcount = 0;
      @(negedge clk);
      occ = 16'h0400; start = 1'b1;
      @(negedge clk);
      start = 1'b0; occ = '0;
      @(negedge clk);
      occ = '1; start = 1'b1;   // R8: arrives mid-slot
      @(negedge clk);
      start = 1'b0; occ = '0;
      for (int k = 0; k < 6; k++) begin
         if (done) dcount++;
         @(negedge clk);
      end
      check(dcount == 1, "R8", "done pulses", 32'(dcount), 32'd1);
      expect_match("R8", 4'b0100, 8'h20);
      g_hold = out_grant;
      repeat (5) @(negedge clk);
      check(out_grant == g_hold && match_valid == 4'b0100 && !done, "R9", "held result",
            32'(out_grant), 32'(g_hold));
   endtask

   task automatic t_empty();
      run_slot('0);
      check(match_valid == '0 && out_grant == '0, "R10", "empty slot",
            32'({match_valid, out_grant}), 32'h0);
   endtask

   task automatic t_random();
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 24; n++) begin
         int bad_max = 0;
         int bad_occ = 0;
         logic [N*N-1:0] pat;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         pat = lfsr;
         run_slot(pat);
         for (int i = 0; i < N; i++) begin
            if (match_valid[i] && !pat[i*N + int'(match_idx[i*W +: W])]) bad_occ++;
            for (int j = 0; j < N; j++) begin
               if (pat[i*N + j] && !match_valid[i] && !(|out_grant[j*N +: N])) bad_max++;
            end
         end
         check(out_grant == grant_of(match_valid, match_idx) && bad_occ == 0, "R5",
               "consistency", 32'(out_grant), 32'(grant_of(match_valid, match_idx)));
         check(bad_max == 0, "R6", "maximal", 32'(bad_max), 32'd0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_full_twice();
      t_input_rotation();
      t_output_rotation();
      t_late_iteration();
      t_busy_start();
      t_empty();
      t_random();
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule